// File: doc/BRIEF.md
# Host/Network CAM Port Arbiter

This block shares one content-addressable memory port between two users: the network filtering path, which runs compare sequences while frames arrive, and a host processor, which reads and writes the CAM through four access addresses. The host can issue a request at any moment, including in the middle of frame processing. A request that cannot be served at once is held inside the block and started as soon as the port is free. The block answers the host with a ready flag that drops when a request is accepted and rises once that access is over.

The network side has strict priority. Whenever the port is free and the network asks for it with network filtering enabled, the network gets it. A host access that has already been granted still runs to the end, so a network request waits at most one host access. A host write holds the port for a fixed number of clocks, set by a parameter. A host read holds the port until the CAM reports valid read data. Clearing the network enable keeps the network off the port, so the host has it to itself.

Top module: `cam_access_arbiter`

## Requirements
- R1: After reset, `host_ready` is 1 and `net_gnt`, `cam_cs`, `cam_we` and `cam_cmd` are 0.
- R2: A `host_req` pulse with `host_addr` in 0x4..0x7, seen while `host_ready` is 1, is accepted and `host_ready` reads 0 in the next cycle. A pulse with any other address is ignored: `host_ready` stays 1 and `cam_cs` stays 0.
- R3: A host write on a free port holds `host_ready` low for WR_CYC+1 cycles. Of these, `cam_cs` and `cam_we` are both high for exactly WR_CYC cycles, starting one cycle after acceptance.
- R4: A host read holds `cam_cs` high with `cam_we` low until `cam_rvalid` is sampled high. The value of `cam_rdata` in that cycle appears on `host_rdata` one cycle later and is held there, and `host_ready` returns high in the same cycle.
- R5: Address bit 1 chooses read (1) or write (0), and address bit 0 chooses data (1) or command (0). During a host access, `cam_cmd` is 1 for addresses 0x4 and 0x6, and `cam_we` is 1 for addresses 0x4 and 0x5.
- R6: When the port is free and `net_req` and `net_en` are both 1, `net_gnt` is 1 in the next cycle, even if a host request is pending or arrives in the same cycle.
- R7: A host request held back by the network starts its port cycle in the cycle after `net_req` is sampled low, unless a new network request wins.
- R8: A network request that arrives during a granted host access does not raise `net_gnt` until that access has finished.
- R9: While `net_en` is 0, `net_gnt` stays 0 whatever `net_req` does. If `net_en` is cleared while the network owns the port, the grant ends in the next cycle.
- R10: While `net_gnt` is 1, `cam_cs` is 1 and `cam_we`, `cam_cmd` and `cam_wdata` follow `net_we`, `net_cmd` and `net_wdata`. During a host write, `cam_wdata` carries the data latched with the request.
- R11: A `host_req` pulse while `host_ready` is 0 is ignored. It does not change the access in progress or the one that is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| net_en | input | 1 | Network filtering enable; 0 leaves the port to the host |
| net_req | input | 1 | Network compare sequence wants or keeps the port (level) |
| net_we | input | 1 | Network write strobe passed to the CAM |
| net_cmd | input | 1 | Network command/data select passed to the CAM |
| net_wdata | input | DATA_W | Network write data |
| net_gnt | output | 1 | Network owns the port |
| host_req | input | 1 | One-cycle host access strobe |
| host_addr | input | ADDR_W | Host register address; 0x4..0x7 are CAM accesses |
| host_wdata | input | DATA_W | Host write data |
| host_ready | output | 1 | High when the host may issue an access |
| host_rdata | output | DATA_W | Data from the last host read |
| cam_cs | output | 1 | CAM cycle active |
| cam_we | output | 1 | CAM write (1) or read (0) |
| cam_cmd | output | 1 | CAM command (1) or data (0) select |
| cam_wdata | output | DATA_W | CAM write data |
| cam_rdata | input | DATA_W | CAM read data |
| cam_rvalid | input | 1 | CAM read data valid |

## Verification
The hardest case to reach from the ports is a network request that lands in the exact cycle a host access finishes, or a host request that sits pending when a network sequence ends and a new one begins. The stimulus builds these on purpose. It lines up `net_req` edges against the known length of the write window, holds network sequences open while host requests are issued, and drops and raises `net_req` back to back. A behavioural reference model in the bench follows every cycle, so each of these races is compared on the grant, chip-select and ready outputs.

// File: rtl/cam_arb_pkg.sv
// Package: shared types for the CAM port arbiter.
// Assumes: state encoding is private to the arbiter and not exported.
package cam_arb_pkg;

    // Who drives the CAM port in the current cycle
    typedef enum logic [1:0] {
        OWN_IDLE = 2'd0,
        OWN_NET  = 2'd1,
        OWN_HWR  = 2'd2,
        OWN_HRD  = 2'd3
    } owner_e;

    // Host operation decoded from the low address bits
    typedef struct packed {
        logic rd;   // 1 = read, 0 = write
        logic dat;  // 1 = data,  0 = command
    } host_op_t;

endpackage

// File: rtl/host_req_latch.sv
// Module: host_req_latch
// Accepts one host CAM access at a time and holds it until the arbiter starts it.
// Assumes: host_req is a one-cycle strobe; requests while not ready are dropped.
module host_req_latch
    import cam_arb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    input  logic              host_busy,
    input  logic              start,
    output logic              pend,
    output host_op_t          op_q,
    output logic [DATA_W-1:0] wdata_q,
    output logic              host_ready
);

    localparam int HI_W = ADDR_W - 2;

    logic addr_hit;
    logic accept;

    // Decode the CAM access window (upper address bits equal 1 -> 0x4..0x7)
    always_comb begin
        addr_hit = (host_addr[ADDR_W-1:2] == HI_W'(1));
    end

    // Ready and accept qualifiers
    always_comb begin
        host_ready = !pend && !host_busy;
        accept     = host_req && addr_hit && host_ready;
    end

    // Pending flag: set on accept, cleared when the arbiter starts the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pend <= 1'b0;
        end else if (accept) begin
            pend <= 1'b1;
        end else if (start) begin
            pend <= 1'b0;
        end
    end

    // Capture operation and write data with the accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= '0;
            wdata_q <= '0;
        end else if (accept) begin
            op_q    <= '{rd: host_addr[1], dat: host_addr[0]};
            wdata_q <= host_wdata;
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !host_ready); // R2
    AST_BUSY_REQ_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (!host_ready) |=> $stable(op_q) && $stable(wdata_q)); // R11

endmodule

// File: rtl/cam_arb_fsm.sv
// Module: cam_arb_fsm
// Chooses the CAM port owner each cycle: network first, then a pending host access.
// Assumes: a granted host access is never pre-empted; reads end on cam_rvalid.
module cam_arb_fsm
    import cam_arb_pkg::*;
#(
    parameter int WR_CYC = 4
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     net_req,
    input  logic     net_en,
    input  logic     pend,
    input  host_op_t op_q,
    input  logic     cam_rvalid,
    output owner_e   owner,
    output logic     start
);

    localparam int CNT_W = (WR_CYC > 1) ? $clog2(WR_CYC) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(WR_CYC - 1);

    logic [CNT_W-1:0] wr_cnt;
    logic             net_want;
    logic             port_free;
    owner_e           owner_nx;

    // Work out whether the port can change hands at the coming edge
    always_comb begin
        net_want = net_req && net_en;
        unique case (owner)
            OWN_IDLE: port_free = 1'b1;
            OWN_NET:  port_free = !net_want;
            OWN_HWR:  port_free = (wr_cnt == LAST);
            OWN_HRD:  port_free = cam_rvalid;
            default:  port_free = 1'b1;
        endcase
    end

    // Next owner: network has priority, then the pending host access
    always_comb begin
        owner_nx = owner;
        start    = 1'b0;
        if (port_free) begin
            if (net_want) begin
                owner_nx = OWN_NET;
            end else if (pend) begin
                owner_nx = op_q.rd ? OWN_HRD : OWN_HWR;
                start    = 1'b1;
            end else begin
                owner_nx = OWN_IDLE;
            end
        end
    end

    // Owner register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            owner <= OWN_IDLE;
        end else begin
            owner <= owner_nx;
        end
    end

    // Write window counter: runs only during a host write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_cnt <= '0;
        end else if (owner == OWN_HWR && wr_cnt != LAST) begin
            wr_cnt <= wr_cnt + 1'b1;
        end else begin
            wr_cnt <= '0;
        end
    end

    AST_WRITE_NOT_PREEMPTED: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_HWR && wr_cnt != LAST) |=> owner == OWN_HWR); // R8
    AST_READ_WAITS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_HRD && !cam_rvalid) |=> owner == OWN_HRD); // R4
    AST_NET_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
        (!net_en) |=> owner != OWN_NET); // R9
    AST_NET_WINS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_IDLE && net_req && net_en) |=> owner == OWN_NET); // R6
    AST_WRITE_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        (owner == OWN_HWR) |-> wr_cnt <= LAST); // R3

endmodule

// File: rtl/cam_port_mux.sv
// Module: cam_port_mux
// Steers the CAM port signals from the current owner and captures host read data.
// Assumes: network control inputs are valid whenever the network owns the port.
module cam_port_mux
    import cam_arb_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  owner_e            owner,
    input  host_op_t          op_q,
    input  logic [DATA_W-1:0] wdata_q,
    input  logic              net_we,
    input  logic              net_cmd,
    input  logic [DATA_W-1:0] net_wdata,
    input  logic [DATA_W-1:0] cam_rdata,
    input  logic              cam_rvalid,
    output logic              cam_cs,
    output logic              cam_we,
    output logic              cam_cmd,
    output logic [DATA_W-1:0] cam_wdata,
    output logic [DATA_W-1:0] host_rdata
);

    // Port signal selection by owner
    always_comb begin
        cam_cs    = 1'b0;
        cam_we    = 1'b0;
        cam_cmd   = 1'b0;
        cam_wdata = '0;
        unique case (owner)
            OWN_NET: begin
                cam_cs    = 1'b1;
                cam_we    = net_we;
                cam_cmd   = net_cmd;
                cam_wdata = net_wdata;
            end
            OWN_HWR, OWN_HRD: begin
                cam_cs    = 1'b1;
                cam_we    = !op_q.rd;
                cam_cmd   = !op_q.dat;
                cam_wdata = wdata_q;
            end
            default: ;
        endcase
    end

    // Capture read data when the CAM reports it valid during a host read
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata <= '0;
        end else if (owner == OWN_HRD && cam_rvalid) begin
            host_rdata <= cam_rdata;
        end
    end

    AST_RDATA_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(owner == OWN_HRD && cam_rvalid) |=> $stable(host_rdata)); // R4

endmodule

// File: rtl/cam_access_arbiter.sv
// Module: cam_access_arbiter (top)
// Shares one CAM port between the network compare path and host accesses.
// Assumes: host accesses use addresses 0x4..0x7; network priority is strict.
module cam_access_arbiter
    import cam_arb_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 16,
    parameter int WR_CYC = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              net_en,
    input  logic              net_req,
    input  logic              net_we,
    input  logic              net_cmd,
    input  logic [DATA_W-1:0] net_wdata,
    output logic              net_gnt,
    input  logic              host_req,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic              host_ready,
    output logic [DATA_W-1:0] host_rdata,
    output logic              cam_cs,
    output logic              cam_we,
    output logic              cam_cmd,
    output logic [DATA_W-1:0] cam_wdata,
    input  logic [DATA_W-1:0] cam_rdata,
    input  logic              cam_rvalid
);

    owner_e            owner;
    host_op_t          op_q;
    logic [DATA_W-1:0] wdata_q;
    logic              pend;
    logic              start;
    logic              host_busy;

    // Owner-derived flags
    always_comb begin
        host_busy = (owner == OWN_HWR) || (owner == OWN_HRD);
        net_gnt   = (owner == OWN_NET);
    end

    host_req_latch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_latch (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_req   (host_req),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_busy  (host_busy),
        .start      (start),
        .pend       (pend),
        .op_q       (op_q),
        .wdata_q    (wdata_q),
        .host_ready (host_ready)
    );

    cam_arb_fsm #(.WR_CYC(WR_CYC)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .net_req    (net_req),
        .net_en     (net_en),
        .pend       (pend),
        .op_q       (op_q),
        .cam_rvalid (cam_rvalid),
        .owner      (owner),
        .start      (start)
    );

    cam_port_mux #(.DATA_W(DATA_W)) u_mux (
        .clk        (clk),
        .rst_n      (rst_n),
        .owner      (owner),
        .op_q       (op_q),
        .wdata_q    (wdata_q),
        .net_we     (net_we),
        .net_cmd    (net_cmd),
        .net_wdata  (net_wdata),
        .cam_rdata  (cam_rdata),
        .cam_rvalid (cam_rvalid),
        .cam_cs     (cam_cs),
        .cam_we     (cam_we),
        .cam_cmd    (cam_cmd),
        .cam_wdata  (cam_wdata),
        .host_rdata (host_rdata)
    );

    AST_GRANT_EXCLUDES_HOST: assert property (@(posedge clk) disable iff (!rst_n)
        (host_busy && !net_gnt && !(owner == OWN_HWR && !cam_we)) |=> !(net_gnt && $past(host_busy) && !$past(u_fsm.port_free))); // R8

endmodule

// File: tb/cam_access_arbiter_tb_top.sv
module cam_access_arbiter_tb_top;

    localparam int ADDR_W = 4;
    localparam int DATA_W = 16;
    localparam int WR_CYC = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic net_en = 1'b1, net_req = 1'b0, net_we = 1'b0, net_cmd = 1'b0;
    logic [DATA_W-1:0] net_wdata = '0;
    logic host_req = 1'b0;
    logic [ADDR_W-1:0] host_addr = '0;
    logic [DATA_W-1:0] host_wdata = '0;
    logic [DATA_W-1:0] cam_rdata = '0;
    logic cam_rvalid = 1'b0;
    logic net_gnt, host_ready, cam_cs, cam_we, cam_cmd;
    logic [DATA_W-1:0] host_rdata, cam_wdata;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    cam_access_arbiter #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WR_CYC(WR_CYC)) dut_i (
        .clk(clk), .rst_n(rst_n), .net_en(net_en), .net_req(net_req),
        .net_we(net_we), .net_cmd(net_cmd), .net_wdata(net_wdata), .net_gnt(net_gnt),
        .host_req(host_req), .host_addr(host_addr), .host_wdata(host_wdata),
        .host_ready(host_ready), .host_rdata(host_rdata),
        .cam_cs(cam_cs), .cam_we(cam_we), .cam_cmd(cam_cmd), .cam_wdata(cam_wdata),
        .cam_rdata(cam_rdata), .cam_rvalid(cam_rvalid)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Behavioural reference: owner 0 none, 1 network, 2 host write, 3 host read
    int m_owner = 0;
    int m_left = 0;
    bit m_pend = 0;
    bit [1:0] m_op = 0;
    int m_wd = 0;
    int m_rd = 0;

    always @(posedge clk) begin
        bit rdy, acc, free, nw;
        if (!rst_n) begin
            m_owner = 0; m_left = 0; m_pend = 0; m_op = 0; m_wd = 0; m_rd = 0;
        end else begin
            rdy  = !m_pend && m_owner < 2;
            acc  = host_req && (host_addr >= 4) && (host_addr <= 7) && rdy;
            nw   = net_req && net_en;
            free = (m_owner == 0) || (m_owner == 1 && !nw) ||
                   (m_owner == 2 && m_left == 1) || (m_owner == 3 && cam_rvalid);
            if (m_owner == 3 && cam_rvalid) m_rd = int'(cam_rdata);
            if (free) begin
                if (nw) m_owner = 1;
                else if (m_pend) begin
                    m_owner = m_op[1] ? 3 : 2;
                    m_left = WR_CYC;
                    m_pend = 0;
                end else m_owner = 0;
            end else if (m_owner == 2) m_left--;
            if (acc) begin
                m_pend = 1; m_op = host_addr[1:0]; m_wd = int'(host_wdata);
            end
        end
    end

    // Per-clock comparison against the reference, away from the active edge
    always @(negedge clk) begin
        int e_we, e_cmd, e_wd;
        if (rst_n) begin
            e_we  = (m_owner == 1) ? int'(net_we)  : (m_owner == 2 ? 1 : 0);
            e_cmd = (m_owner == 1) ? int'(net_cmd) : (m_owner >= 2 ? int'(!m_op[0]) : 0);
            e_wd  = (m_owner == 1) ? int'(net_wdata) : (m_owner >= 2 ? m_wd : 0);
            chk(host_ready == (!m_pend && m_owner < 2), "R2", host_ready, (!m_pend && m_owner < 2));
            chk(net_gnt == (m_owner == 1), "R6", net_gnt, m_owner == 1);
            chk(cam_cs == (m_owner != 0), "R3", cam_cs, m_owner != 0);
            chk(int'(cam_we) == e_we, "R5", cam_we, e_we);
            chk(int'(cam_cmd) == e_cmd, "R5", cam_cmd, e_cmd);
            chk(int'(cam_wdata) == e_wd, "R10", cam_wdata, e_wd);
            chk(int'(host_rdata) == m_rd, "R4", host_rdata, m_rd);
        end
    end

    task automatic step(input int n);
        repeat (n) begin @(negedge clk); #1; end
    endtask

    task automatic host_issue(input int addr, input int wd);
        host_req = 1; host_addr = ADDR_W'(addr); host_wdata = DATA_W'(wd);
        step(1);
        host_req = 0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int lo, cs_n;
        step(3);
        @(negedge clk);
        chk(host_ready && !net_gnt && !cam_cs && !cam_we && !cam_cmd, "R1",
            {host_ready, net_gnt, cam_cs}, 3'b100);
        #1 rst_n = 1;
        step(2);

        // R3: command write on a free port, measure windows
        host_issue(4, 16'hA5A5);
        lo = 1; cs_n = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (cam_cs && cam_we) cs_n++;
            if (!host_ready) lo++; else break;
        end
        chk(lo == WR_CYC + 1, "R3", lo, WR_CYC + 1);
        chk(cs_n == WR_CYC, "R3", cs_n, WR_CYC);
        step(2);

        // R5: data write
        host_issue(5, 16'h1234);
        step(WR_CYC + 3);

        // R4: command read with late valid
        host_issue(6, 0);
        step(3);
        cam_rdata = 16'hBEEF; cam_rvalid = 1;
        step(1);
        cam_rvalid = 0; cam_rdata = 16'h0;
        chk(host_rdata == 16'hBEEF, "R4", host_rdata, 16'hBEEF);
        chk(host_ready, "R4", host_ready, 1);
        step(2);

        // R2: addresses outside the window are ignored
        host_issue(2, 16'h5555);
        chk(host_ready && !cam_cs, "R2", {host_ready, cam_cs}, 2'b10);
        host_issue(8, 16'h6666);
        step(1);
        chk(host_ready && !cam_cs, "R2", {host_ready, cam_cs}, 2'b10);

        // R11: second request while busy is dropped
        host_issue(4, 16'h0F0F);
        host_issue(7, 16'hF0F0);
        step(WR_CYC + 4);
        chk(!cam_cs && host_ready, "R11", cam_cs, 0);

        // R6 / R7: network holds port, host waits, starts after net_req drops
        net_req = 1; net_we = 1; net_cmd = 1; net_wdata = 16'hC0DE;
        host_issue(5, 16'h7777);
        chk(net_gnt && !host_ready, "R6", net_gnt, 1);
        step(3);
        net_req = 0; net_we = 0; net_cmd = 0;
        step(1);
        chk(cam_cs && !net_gnt && cam_wdata == 16'h7777, "R7", cam_wdata, 16'h7777);
        step(WR_CYC + 2);

        // R6: simultaneous host and network requests, network first
        net_req = 1; host_req = 1; host_addr = 4'h7; host_wdata = 0;
        step(1);
        host_req = 0;
        chk(net_gnt, "R6", net_gnt, 1);
        step(1);
        net_req = 0;
        step(2);
        cam_rdata = 16'h4242; cam_rvalid = 1;
        step(1);
        cam_rvalid = 0;
        chk(host_rdata == 16'h4242, "R4", host_rdata, 16'h4242);
        step(2);

        // R8: network request during a granted host write waits
        host_issue(4, 16'h1111);
        step(1);
        net_req = 1; net_wdata = 16'h2222;
        step(1);
        chk(!net_gnt && cam_wdata == 16'h1111, "R8", net_gnt, 0);
        step(WR_CYC);
        chk(net_gnt, "R8", net_gnt, 1);
        // R9: clearing enable drops the grant
        net_en = 0;
        step(1);
        chk(!net_gnt, "R9", net_gnt, 0);
        host_issue(4, 16'h3333);
        step(WR_CYC + 2);
        chk(!net_gnt && host_ready, "R9", net_gnt, 0);
        net_en = 1;
        step(1);
        net_req = 0;
        // back-to-back network bursts with host pending
        host_issue(6, 0);
        net_req = 1;
        step(2);
        net_req = 0;
        step(1);
        net_req = 1;
        step(1);
        net_req = 0;
        step(2);
        cam_rdata = 16'h9999; cam_rvalid = 1;
        step(1);
        cam_rvalid = 0;
        step(3);
        chk(host_ready && host_rdata == 16'h9999, "R7", host_rdata, 16'h9999);

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule